// File: doc/BRIEF.md
# Serial-Programmed Glitch-Free Output Freeze Controller

This block sits after a bank of twelve clock dividers that all run from one fast clock. It passes each divided clock to its own output pin, or holds that pin low ("frozen"). A slow serial port, made of a data line and a shift clock, selects which outputs run. The dividers are never stopped. A frozen output therefore resumes in phase with the outputs that kept running. An enable change only takes effect on a fast-clock edge where that output's divided clock is low, so no output ever produces a shortened pulse.

The serial lines are asynchronous to the fast clock. Each passes through a two-flop synchronizer, and the bench-visible shift clock edge is detected in the fast domain. A deframer state machine has two states. In `SH_COLLECT` it shifts one bit per rising shift-clock edge and counts bits. On the twelfth bit it takes the transition *frame_done* to `SH_COMMIT`. There it copies the word into the holding register, then takes *commit_done* back to `SH_COLLECT`. Each output has a two-state cell. It moves between `G_RUN` and `G_FROZEN` through the transitions *freeze* and *thaw*, and only on an edge where its raw clock sampled low.

Top module: `outfrz_top`

## Requirements
- R1: After the power-on reset is released, all twelve outputs are enabled, so each output equals its raw divided clock.
- R2: A frame is 12 bits, sampled on rising edges of the serial shift clock, most significant bit first. The first bit received controls output 11 and the last bit controls output 0.
- R3: A bit value of 0 freezes its output, which is then held low for as long as the bit stays 0.
- R4: The received word takes effect only after the twelfth bit. While a frame is partly shifted, every output keeps its previous enable.
- R5: An output's enable changes only on a fast-clock edge where that output's raw clock is low. Every rising edge of an output coincides with a rising edge of its raw clock, and every falling edge coincides with a falling edge of its raw clock.
- R6: A bit value of 1 enables its output. An output that is re-enabled after a freeze equals its raw clock cycle for cycle, in phase with the outputs that were never frozen.
- R7: Consecutive frames are each applied in turn. The bit counter restarts at zero after each commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that also drives the dividers |
| rst_n | input | 1 | Active-low power-on reset |
| raw_clk | input | 12 | Divided clocks from the dividers, synchronous to clk |
| ser_sck | input | 1 | Serial shift clock, asynchronous |
| ser_sdi | input | 1 | Serial data, sampled on rising ser_sck |
| out_clk | output | 12 | Gated clocks, low when frozen |

## Verification
The critical coincidence is a commit of a new word landing in a cycle where an affected output's raw clock is high. The freeze or thaw must then wait for the low phase rather than cut the pulse. The bench runs the twelve raw clocks at four different half-periods, so successive commits land on both high and low phases across the outputs. A monitor judges every cycle of every output. Each rise of an output must coincide with a rise of its raw clock, and each fall with a fall of its raw clock. The scoreboard separately confirms the steady-state gating.

// File: rtl/outfrz_pkg.sv
package outfrz_pkg;
    localparam int unsigned N_OUT = 12;

    typedef enum logic {
        SH_COLLECT = 1'b0,
        SH_COMMIT  = 1'b1
    } sh_state_t;

    typedef enum logic {
        G_RUN    = 1'b0,
        G_FROZEN = 1'b1
    } gate_state_t;
endpackage

// File: rtl/outfrz_sync.sv
module outfrz_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage[s] <= '0;
        end else begin
            stage[0] <= d_async;
            for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
        end
    end

    assign d_sync = stage[STAGES-1];
endmodule

// File: rtl/outfrz_deframer.sv
module outfrz_deframer
    import outfrz_pkg::*;
#(
    parameter int unsigned WORD_W = N_OUT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              sdi_s,
    output logic [WORD_W-1:0] hold_word
);
    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    sh_state_t         state, state_nx;
    logic              sck_q;
    logic              sck_rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shreg;

    assign sck_rise = sck_s & ~sck_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            SH_COLLECT: if (sck_rise && bit_cnt == LAST) state_nx = SH_COMMIT;
            SH_COMMIT:  state_nx = SH_COLLECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_COLLECT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q     <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            hold_word <= '1;
        end else begin
            sck_q <= sck_s;
            unique case (state)
                SH_COLLECT: begin
                    if (sck_rise) begin
                        shreg   <= {shreg[WORD_W-2:0], sdi_s};
                        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
                    end
                end
                SH_COMMIT: hold_word <= shreg;
            endcase
        end
    end

    // R4 / R7: a commit only follows the last bit of a frame
    a_r4_commit_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SH_COMMIT) |-> ($past(bit_cnt) == LAST && $past(sck_rise)));
    // R4: the holding word only moves in the commit state
    a_r4_hold_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hold_word) |-> ($past(state) == SH_COMMIT));
    // R7: counter stays within a frame
    a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= LAST);
endmodule

// File: rtl/outfrz_gate.sv
module outfrz_gate
    import outfrz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic want_on,
    output logic gated
);
    gate_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            G_RUN:    if (!raw && !want_on) state_nx = G_FROZEN;  // freeze
            G_FROZEN: if (!raw &&  want_on) state_nx = G_RUN;     // thaw
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= G_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            G_RUN:    gated = raw;
            G_FROZEN: gated = 1'b0;
        endcase
    end

    // R5: enable moves only on an edge where raw was low
    a_r5_change_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state) |-> !$past(raw));
    // R5: output rises only together with raw
    a_r5_rise_with_raw: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gated) |-> $rose(raw));
    // R5: output falls only together with raw
    a_r5_fall_with_raw: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gated) |-> $fell(raw));
    // R3: a frozen output is low
    a_r3_frozen_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == G_FROZEN) |-> !gated);
endmodule

// File: rtl/outfrz_top.sv
module outfrz_top
    import outfrz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_OUT-1:0]  raw_clk,
    input  logic              ser_sck,
    input  logic              ser_sdi,
    output logic [N_OUT-1:0]  out_clk
);
    logic [1:0]       ser_s;
    logic [N_OUT-1:0] hold_word;

    outfrz_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ser_sck, ser_sdi}),
        .d_sync  (ser_s)
    );

    outfrz_deframer #(.WORD_W(N_OUT)) u_deframer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (ser_s[1]),
        .sdi_s     (ser_s[0]),
        .hold_word (hold_word)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_gate
        outfrz_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw     (raw_clk[g]),
            .want_on (hold_word[g]),
            .gated   (out_clk[g])
        );
    end

    // R1: first cycle after reset every output follows its raw clock
    a_r1_all_on_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (out_clk == raw_clk));
endmodule

// File: tb/outfrz_top_bench.sv
module outfrz_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] raw_clk = '0;
    logic        ser_sck = 1'b0;
    logic        ser_sdi = 1'b0;
    logic [11:0] out_clk;

    int checks = 0;
    int errors = 0;
    int runt_bad = 0;
    bit mon_busy = 1'b0;
    bit done = 1'b0;

    logic [11:0] q_word[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    outfrz_top u_outfrz_top (
        .clk(clk), .rst_n(rst_n), .raw_clk(raw_clk),
        .ser_sck(ser_sck), .ser_sdi(ser_sdi), .out_clk(out_clk)
    );

    // raw divided clocks, half-periods 1..4 cycles
    int rcnt[12];
    initial for (int i = 0; i < 12; i++) rcnt[i] = 0;
    always @(negedge clk) begin
        for (int i = 0; i < 12; i++) begin
            if (rcnt[i] >= (i % 4)) begin
                rcnt[i] = 0;
                raw_clk[i] <= ~raw_clk[i];
            end else begin
                rcnt[i] = rcnt[i] + 1;
            end
        end
    end

    // R5 runt monitor: edges of outputs only with edges of raw
    logic [11:0] p_out = '0, p_raw = '0;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            for (int i = 0; i < 12; i++) begin
                if (out_clk[i] && !p_out[i] && !(raw_clk[i] && !p_raw[i])) runt_bad++;
                if (!out_clk[i] && p_out[i] && !(!raw_clk[i] && p_raw[i])) runt_bad++;
            end
        end
        p_out = out_clk;
        p_raw = raw_clk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_bits(input logic [11:0] w, input int first, input int last);
        for (int b = first; b >= last; b--) begin
            @(negedge clk);
            ser_sdi = w[b];
            repeat (4) @(negedge clk);
            ser_sck = 1'b1;
            repeat (4) @(negedge clk);
            ser_sck = 1'b0;
        end
    endtask

    task automatic expect_word(input logic [11:0] w, input string tag);
        q_word.push_back(w);
        q_tag.push_back(tag);
        mon_busy = 1'b1;
        wait (q_word.size() == 0 && !mon_busy);
    endtask

    // monitor: pops expected enables and compares over a window
    initial begin
        forever begin
            wait (q_word.size() > 0);
            repeat (14) @(negedge clk);
            begin
                logic [11:0] w;
                string tag;
                int bad[12];
                w = q_word.pop_front();
                tag = q_tag.pop_front();
                for (int i = 0; i < 12; i++) bad[i] = 0;
                for (int c = 0; c < 24; c++) begin
                    @(negedge clk);
                    #1;
                    for (int i = 0; i < 12; i++)
                        if (out_clk[i] !== (raw_clk[i] & w[i])) bad[i]++;
                end
                for (int i = 0; i < 12; i++)
                    check(bad[i] == 0, w[i] ? {tag, "/R6"} : {tag, "/R3"},
                          $sformatf("out %0d mismatch cycles", i), bad[i], 0);
            end
            mon_busy = 1'b0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        expect_word(12'hFFF, "R1 reset");
        send_bits(12'hA5C, 11, 0);
        expect_word(12'hA5C, "R2 msb-first");
        send_bits(12'h000, 11, 6);
        expect_word(12'hA5C, "R4 partial");
        send_bits(12'h000, 5, 0);
        expect_word(12'h000, "R4 complete");
        send_bits(12'hFFF, 11, 0);
        expect_word(12'hFFF, "R7 thaw all");
        send_bits(12'h3C3, 11, 0);
        expect_word(12'h3C3, "R7 next");
        send_bits(12'h5A6, 11, 0);
        expect_word(12'h5A6, "R7 next2");
        check(runt_bad == 0, "R5", "runt edges", runt_bad, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule